// File: doc/BRIEF.md
# DMA Request Arbiter and Transfer Sequencer

This block sits between a set of peripheral DMA request lines and a host processor bus. When any enabled channel asks for service, it requests the bus from the host with a hold request. It then waits for the hold acknowledge, picks the winning channel by fixed priority and runs one single-byte transfer cycle. During that cycle it drives the paired memory and I/O strobes and selects the peripheral through that channel's acknowledge line. Address and byte-count arithmetic live in a neighbouring channel register block. That block is told when a byte moves (`xfer_step`) and reports when a channel is on its last byte (`tc_hit`).

Each transfer walks four states, S1 to S4. The strobes are active in S2 and S3, and S3 repeats while `ready` is low. Request and acknowledge levels are programmable per channel. A channel ends when it reaches terminal count, which the block signals on `eop_out`, or when an external end-of-process arrives on `eop_in`. Either way the channel's mask bit is set and the channel drops out of arbitration. The masks start all set after reset, and the host loads them all at once.

Top module: `dma_xfer_seq`

## Requirements
- R1: Channel i requests service when `dreq_raw[i]` equals `dreq_pol[i]` (1 = active-high, 0 = active-low) and its mask bit is clear.
- R2: Each `dack_raw[i]` rests at `~dack_pol[i]`. The selected channel's line takes level `dack_pol[i]` from S1 through S4, and at most one channel is selected.
- R3: From idle, a pending request raises `hold_req` on the next clock. No transfer state, strobe or acknowledge is driven until `hold_ack` has been sampled high.
- R4: When several requests are pending, the lowest-numbered channel wins. The choice is made when a transfer starts.
- R5: With `chan_is_read[ch]`=1 (memory to peripheral), `mem_rd` and `io_wr` are high together. With 0 (peripheral to memory), `mem_wr` and `io_rd` are high together. Strobe bits are ordered {mem_rd, mem_wr, io_rd, io_wr} in the bench.
- R6: Each transfer takes S1, S2, S3 and S4 of one clock each. Strobes are high in S2 and S3, and S3 repeats while `ready` is low.
- R7: In S4, `eop_out` is high when `tc_hit` of the active channel is high. After such a transfer the channel is masked.
- R8: `eop_in` high in any of S1 to S4 masks the active channel at the end of S4. `eop_in` outside a transfer has no effect.
- R9: Reset sets every mask bit. `mask_wr` loads `mask_wdata` into all mask bits (1 = masked). A termination in the same clock still sets the terminated channel's bit.
- R10: `bus_own` is high exactly in S1 to S4.
- R11: After S4, the block starts the next transfer at S1 if a request is still pending, and `hold_req` stays high. Otherwise `hold_req` falls on the next clock.
- R12: `xfer_step` is a one-clock pulse in S4 of every transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dreq_raw | input | NCH | Request lines at pin level |
| dreq_pol | input | NCH | Request active level per channel |
| dack_pol | input | NCH | Acknowledge active level per channel |
| chan_is_read | input | NCH | 1 = memory-to-peripheral channel |
| mask_wr | input | 1 | Load all mask bits |
| mask_wdata | input | NCH | New mask value, 1 = masked |
| hold_ack | input | 1 | Bus grant from host |
| ready | input | 1 | Low stretches S3 |
| tc_hit | input | NCH | Channel is on its final byte |
| eop_in | input | 1 | External end-of-process |
| hold_req | output | 1 | Bus request to host |
| dack_raw | output | NCH | Acknowledge lines at pin level |
| bus_own | output | 1 | Address enable, high while owning the bus |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| eop_out | output | 1 | Terminal-count end-of-process |
| xfer_step | output | 1 | Byte moved, advance address and count |

## Verification
A host write to the mask bits and a channel's own termination can land on the same clock edge, at the end of S4. The bench provokes this by pulsing `mask_wr` with all zeros during the S4 of a transfer that also has `tc_hit` set. It then judges the result by watching `hold_req`: it must stay low on the following clocks while that channel's request is still held active. A second overlap, where a termination is followed at once by a lower-priority channel's transfer, is checked through the acknowledge pattern in the S1 that follows.

// File: rtl/dma_pkg.sv
// Shared types for the DMA transfer sequencer.
package dma_pkg;
    // Bus cycle states: idle, awaiting grant, then the four transfer states.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_HOLD = 3'd1,
        ST_S1   = 3'd2,
        ST_S2   = 3'd3,
        ST_S3   = 3'd4,
        ST_S4   = 3'd5
    } dma_state_e;
endpackage

// File: rtl/dma_req_cond.sv
// Request conditioner: turns pin-level requests into active-high pending bits.
// Assumes the requests are already synchronous to clk.
module dma_req_cond #(
    parameter int NCH = 4
) (
    input  logic [NCH-1:0] dreq_raw,
    input  logic [NCH-1:0] dreq_pol,
    input  logic [NCH-1:0] mask_eff,
    output logic [NCH-1:0] pend
);
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        // A channel is pending when its pin matches its active level and it is unmasked.
        assign pend[i] = (dreq_raw[i] == dreq_pol[i]) && !mask_eff[i];
    end
endmodule

// File: rtl/dma_prio_arb.sv
// Fixed-priority arbiter: the lowest index wins. Purely combinational.
module dma_prio_arb #(
    parameter int NCH = 4,
    parameter int CW  = 2
) (
    input  logic [NCH-1:0] req,
    output logic [CW-1:0]  win,
    output logic           any
);
    // Scan from the highest index down so that the lowest index is written last.
    always_comb begin
        win = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) win = CW'(i);
        end
        any = |req;
    end
endmodule

// File: rtl/dma_cycle_fsm.sv
// Transfer sequencer: asks for the bus, waits for the grant, runs S1..S4 with
// wait states in S3, and reports a termination of the active channel in S4.
// Assumes hold_ack stays high for as long as the bus is owned.
module dma_cycle_fsm
    import dma_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           any_pend,
    input  logic [CW-1:0]  win_ch,
    input  logic           hold_ack,
    input  logic           ready,
    input  logic           eop_in,
    input  logic [NCH-1:0] tc_hit,
    output dma_state_e     state,
    output logic [CW-1:0]  cur_ch,
    output logic           term_now
);
    dma_state_e nxt;
    logic       eop_seen;
    logic       in_xfer;

    assign in_xfer = (state == ST_S1) || (state == ST_S2) || (state == ST_S3);

    // The active channel ends in S4 on terminal count or an external end-of-process.
    assign term_now = (state == ST_S4) && (tc_hit[cur_ch] || eop_seen || eop_in);

    // Next-state selection.
    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE: if (any_pend) nxt = ST_HOLD;
            ST_HOLD: begin
                if (!any_pend)     nxt = ST_IDLE;
                else if (hold_ack) nxt = ST_S1;
            end
            ST_S1:   nxt = ST_S2;
            ST_S2:   nxt = ST_S3;
            ST_S3:   if (ready) nxt = ST_S4;
            ST_S4:   nxt = (any_pend && hold_ack) ? ST_S1 : ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // State register and channel latch, loaded whenever S1 is entered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cur_ch <= '0;
        end else begin
            state <= nxt;
            if (nxt == ST_S1) cur_ch <= win_ch;
        end
    end

    // Remembers an external end-of-process seen in S1..S3 until S4 ends.
    always_ff @(posedge clk) begin
        if (!rst_n)                eop_seen <= 1'b0;
        else if (state == ST_S4)   eop_seen <= 1'b0;
        else if (in_xfer && eop_in) eop_seen <= 1'b1;
    end
endmodule

// File: rtl/dma_strobe_gen.sv
// Output decoder: bus ownership, acknowledge levels, paired strobes and
// transfer pulses, all decoded from the registered state and channel.
module dma_strobe_gen
    import dma_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 2
) (
    input  dma_state_e     state,
    input  logic [CW-1:0]  cur_ch,
    input  logic [NCH-1:0] chan_is_read,
    input  logic [NCH-1:0] dack_pol,
    input  logic [NCH-1:0] tc_hit,
    output logic           hold_req,
    output logic           bus_own,
    output logic [NCH-1:0] dack_raw,
    output logic           mem_rd,
    output logic           mem_wr,
    output logic           io_rd,
    output logic           io_wr,
    output logic           eop_out,
    output logic           xfer_step
);
    logic strobe_on;
    logic rd_dir;
    logic in_s4;

    assign in_s4     = (state == ST_S4);
    assign bus_own   = (state == ST_S1) || (state == ST_S2) || (state == ST_S3) || in_s4;
    assign hold_req  = (state != ST_IDLE);
    assign strobe_on = (state == ST_S2) || (state == ST_S3);
    assign rd_dir    = chan_is_read[cur_ch];

    // Strobes are paired in opposite directions for the two transfer kinds.
    assign mem_rd    = strobe_on && rd_dir;
    assign io_wr     = strobe_on && rd_dir;
    assign mem_wr    = strobe_on && !rd_dir;
    assign io_rd     = strobe_on && !rd_dir;

    assign eop_out   = in_s4 && tc_hit[cur_ch];
    assign xfer_step = in_s4;

    for (genvar i = 0; i < NCH; i++) begin : g_ack
        // The selected channel's line takes its active level; all others rest.
        assign dack_raw[i] = (bus_own && (cur_ch == CW'(i))) ? dack_pol[i] : !dack_pol[i];
    end
endmodule

// File: rtl/dma_xfer_seq.sv
// DMA request arbiter and transfer sequencer top. Holds the channel masks and
// connects conditioner, arbiter, sequencer and output decoder.
// Assumes requests are synchronous; address/count logic is external.
module dma_xfer_seq
    import dma_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] dreq_raw,
    input  logic [NCH-1:0] dreq_pol,
    input  logic [NCH-1:0] dack_pol,
    input  logic [NCH-1:0] chan_is_read,
    input  logic           mask_wr,
    input  logic [NCH-1:0] mask_wdata,
    input  logic           hold_ack,
    input  logic           ready,
    input  logic [NCH-1:0] tc_hit,
    input  logic           eop_in,
    output logic           hold_req,
    output logic [NCH-1:0] dack_raw,
    output logic           bus_own,
    output logic           mem_rd,
    output logic           mem_wr,
    output logic           io_rd,
    output logic           io_wr,
    output logic           eop_out,
    output logic           xfer_step
);
    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;

    dma_state_e     state;
    logic [CW-1:0]  cur_ch;
    logic [CW-1:0]  win_ch;
    logic           any_pend;
    logic           term_now;
    logic [NCH-1:0] mask_q;
    logic [NCH-1:0] mask_d;
    logic [NCH-1:0] term_bits;
    logic [NCH-1:0] pend;

    // Next mask: a host write, then any termination of the active channel on top.
    always_comb begin
        term_bits = '0;
        if (term_now) term_bits[cur_ch] = 1'b1;
        mask_d = (mask_wr ? mask_wdata : mask_q) | term_bits;
    end

    // Mask register; reset leaves every channel disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '1;
        else        mask_q <= mask_d;
    end

    dma_req_cond #(.NCH(NCH)) cond_i (
        .dreq_raw (dreq_raw),
        .dreq_pol (dreq_pol),
        .mask_eff (mask_d),
        .pend     (pend)
    );

    dma_prio_arb #(.NCH(NCH), .CW(CW)) arb_i (
        .req (pend),
        .win (win_ch),
        .any (any_pend)
    );

    dma_cycle_fsm #(.NCH(NCH), .CW(CW)) fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .any_pend (any_pend),
        .win_ch   (win_ch),
        .hold_ack (hold_ack),
        .ready    (ready),
        .eop_in   (eop_in),
        .tc_hit   (tc_hit),
        .state    (state),
        .cur_ch   (cur_ch),
        .term_now (term_now)
    );

    dma_strobe_gen #(.NCH(NCH), .CW(CW)) out_i (
        .state        (state),
        .cur_ch       (cur_ch),
        .chan_is_read (chan_is_read),
        .dack_pol     (dack_pol),
        .tc_hit       (tc_hit),
        .hold_req     (hold_req),
        .bus_own      (bus_own),
        .dack_raw     (dack_raw),
        .mem_rd       (mem_rd),
        .mem_wr       (mem_wr),
        .io_rd        (io_rd),
        .io_wr        (io_wr),
        .eop_out      (eop_out),
        .xfer_step    (xfer_step)
    );
endmodule

// File: rtl/dma_xfer_seq_chk.sv
// Port-level property checker for dma_xfer_seq, attached by bind below.
module dma_xfer_seq_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           hold_req,
    input logic           hold_ack,
    input logic           ready,
    input logic           bus_own,
    input logic [NCH-1:0] dack_raw,
    input logic [NCH-1:0] dack_pol,
    input logic           mem_rd,
    input logic           mem_wr,
    input logic           io_rd,
    input logic           io_wr,
    input logic           eop_out,
    input logic           xfer_step
);
    logic [NCH-1:0] dack_act;
    logic           any_strobe;

    assign dack_act   = ~(dack_raw ^ dack_pol);
    assign any_strobe = mem_rd || mem_wr || io_rd || io_wr;

    // R2
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_own |-> ($countones(dack_act) == 1));
    // R2
    ack_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_own |-> (dack_act == '0));
    // R3
    grant_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_own) |-> $past(hold_ack));
    // R5
    read_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (io_wr && !mem_wr && !io_rd));
    // R5
    write_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (io_rd && !mem_rd && !io_wr));
    // R6
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (any_strobe && !ready) |=> any_strobe);
    // R7
    eop_in_s4_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eop_out |-> xfer_step);
    // R10
    own_needs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_own || any_strobe) |-> (hold_req && bus_own));
    // R11
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_own) |-> !hold_req);
    // R12
    step_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_step |=> !xfer_step);
endmodule

bind dma_xfer_seq dma_xfer_seq_chk #(.NCH(NCH)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_req  (hold_req),
    .hold_ack  (hold_ack),
    .ready     (ready),
    .bus_own   (bus_own),
    .dack_raw  (dack_raw),
    .dack_pol  (dack_pol),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .io_rd     (io_rd),
    .io_wr     (io_wr),
    .eop_out   (eop_out),
    .xfer_step (xfer_step)
);

// File: tb/dma_xfer_seq_tb_top.sv
// Bench: a per-cycle vector table, then directed tests for masks, reset and
// end-of-process corners. Inputs change after the falling edge; outputs are
// compared at the next falling edge.
module dma_xfer_seq_tb_top;
    localparam int NCH = 4;
    localparam int NV  = 25;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [NCH-1:0] dreq_raw, dreq_pol, dack_pol, chan_is_read, mask_wdata, tc_hit;
    logic           mask_wr, hold_ack, ready, eop_in;
    logic           hold_req, bus_own, mem_rd, mem_wr, io_rd, io_wr, eop_out, xfer_step;
    logic [NCH-1:0] dack_raw;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    dma_xfer_seq #(.NCH(NCH)) dut_i (
        .clk(clk), .rst_n(rst_n), .dreq_raw(dreq_raw), .dreq_pol(dreq_pol),
        .dack_pol(dack_pol), .chan_is_read(chan_is_read), .mask_wr(mask_wr),
        .mask_wdata(mask_wdata), .hold_ack(hold_ack), .ready(ready),
        .tc_hit(tc_hit), .eop_in(eop_in), .hold_req(hold_req), .dack_raw(dack_raw),
        .bus_own(bus_own), .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd),
        .io_wr(io_wr), .eop_out(eop_out), .xfer_step(xfer_step)
    );

    // Fields: dreq[21:18] hack[17] rdy[16] tc[15:12] eopi[11] |
    //         hrq[10] own[9] dack[8:5] strobes{mrd,mwr,ior,iow}[4:1] eopo[0]
    // Config: dreq_pol=1011 (ch2 active-low), dack_pol=1101 (ch1 active-low),
    //         chan_is_read=0101; resting dack pattern 0010.
    localparam logic [21:0] TBL [0:NV-1] = '{
        {4'b0100,1'b0,1'b1,4'b0000,1'b0, 1'b0,1'b0,4'b0010,4'b0000,1'b0}, // 0 idle, R1 ch2 raw high is inactive
        {4'b0101,1'b0,1'b1,4'b0000,1'b0, 1'b1,1'b0,4'b0010,4'b0000,1'b0}, // 1 R3 hold request
        {4'b0101,1'b0,1'b1,4'b0000,1'b0, 1'b1,1'b0,4'b0010,4'b0000,1'b0}, // 2 R3 no grant yet
        {4'b0101,1'b1,1'b1,4'b0000,1'b0, 1'b1,1'b1,4'b0011,4'b0000,1'b0}, // 3 S1 ch0
        {4'b0101,1'b1,1'b1,4'b0000,1'b0, 1'b1,1'b1,4'b0011,4'b1001,1'b0}, // 4 S2 read pair
        {4'b0101,1'b1,1'b0,4'b0000,1'b0, 1'b1,1'b1,4'b0011,4'b1001,1'b0}, // 5 S3
        {4'b0101,1'b1,1'b0,4'b0000,1'b0, 1'b1,1'b1,4'b0011,4'b1001,1'b0}, // 6 R6 wait state
        {4'b0101,1'b1,1'b1,4'b0000,1'b0, 1'b1,1'b1,4'b0011,4'b0000,1'b0}, // 7 S4
        {4'b0100,1'b1,1'b1,4'b0000,1'b0, 1'b0,1'b0,4'b0010,4'b0000,1'b0}, // 8 R11 release
        {4'b1110,1'b1,1'b1,4'b0000,1'b0, 1'b1,1'b0,4'b0010,4'b0000,1'b0}, // 9 ch1+ch3 pending
        {4'b1110,1'b1,1'b1,4'b0000,1'b0, 1'b1,1'b1,4'b0000,4'b0000,1'b0}, // 10 R4 ch1 wins, low ack
        {4'b1110,1'b1,1'b1,4'b0000,1'b0, 1'b1,1'b1,4'b0000,4'b0110,1'b0}, // 11 write pair
        {4'b1110,1'b1,1'b1,4'b0000,1'b0, 1'b1,1'b1,4'b0000,4'b0110,1'b0}, // 12 S3
        {4'b1110,1'b1,1'b1,4'b0010,1'b0, 1'b1,1'b1,4'b0000,4'b0000,1'b1}, // 13 S4 R7 terminal count
        {4'b1110,1'b1,1'b1,4'b0010,1'b0, 1'b1,1'b1,4'b1010,4'b0000,1'b0}, // 14 R11 back-to-back ch3
        {4'b1110,1'b1,1'b1,4'b0000,1'b0, 1'b1,1'b1,4'b1010,4'b0110,1'b0}, // 15 S2
        {4'b1110,1'b1,1'b1,4'b0000,1'b1, 1'b1,1'b1,4'b1010,4'b0110,1'b0}, // 16 R8 external end in S2
        {4'b1110,1'b1,1'b1,4'b0000,1'b0, 1'b1,1'b1,4'b1010,4'b0000,1'b0}, // 17 S4
        {4'b1110,1'b1,1'b1,4'b0000,1'b0, 1'b0,1'b0,4'b0010,4'b0000,1'b0}, // 18 R7 R8 both masked
        {4'b0000,1'b1,1'b1,4'b0000,1'b0, 1'b1,1'b0,4'b0010,4'b0000,1'b0}, // 19 R1 ch2 raw low active
        {4'b0000,1'b1,1'b1,4'b0000,1'b0, 1'b1,1'b1,4'b0110,4'b0000,1'b0}, // 20 S1 ch2
        {4'b0000,1'b1,1'b1,4'b0000,1'b0, 1'b1,1'b1,4'b0110,4'b1001,1'b0}, // 21 S2
        {4'b0000,1'b1,1'b1,4'b0000,1'b0, 1'b1,1'b1,4'b0110,4'b1001,1'b0}, // 22 S3
        {4'b0000,1'b1,1'b1,4'b0000,1'b0, 1'b1,1'b1,4'b0110,4'b0000,1'b0}, // 23 S4
        {4'b0100,1'b1,1'b1,4'b0000,1'b0, 1'b0,1'b0,4'b0010,4'b0000,1'b0}  // 24 idle
    };

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [3:0] strb();
        return {mem_rd, mem_wr, io_rd, io_wr};
    endfunction

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R11 watchdog got hang expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; dreq_raw = 4'b0100; dreq_pol = 4'b1011; dack_pol = 4'b1101;
        chan_is_read = 4'b0101; mask_wr = 1'b0; mask_wdata = '0; hold_ack = 1'b0;
        ready = 1'b1; tc_hit = '0; eop_in = 1'b0;
        repeat (2) step();
        rst_n = 1'b1;
        step();
        // Reset state
        chk("R3 reset hold_req", 8'(hold_req), 8'd0);
        chk("R10 reset bus_own", 8'(bus_own), 8'd0);
        chk("R2 reset dack", 8'(dack_raw), 8'h2);
        chk("R5 reset strobes", 8'(strb()), 8'h0);

        mask_wr = 1'b1; mask_wdata = 4'b0000;
        step();
        mask_wr = 1'b0;

        for (int k = 0; k < NV; k++) begin
            dreq_raw = TBL[k][21:18]; hold_ack = TBL[k][17]; ready = TBL[k][16];
            tc_hit = TBL[k][15:12]; eop_in = TBL[k][11];
            step();
            chk($sformatf("R3/R11 hold_req v%0d", k), 8'(hold_req), 8'(TBL[k][10]));
            chk($sformatf("R10 bus_own v%0d", k), 8'(bus_own), 8'(TBL[k][9]));
            chk($sformatf("R2/R4 dack v%0d", k), 8'(dack_raw), 8'(TBL[k][8:5]));
            chk($sformatf("R5/R6 strobes v%0d", k), 8'(strb()), 8'(TBL[k][4:1]));
            chk($sformatf("R7 eop_out v%0d", k), 8'(eop_out), 8'(TBL[k][0]));
        end
        tc_hit = '0; eop_in = 1'b0;

        // R8: end-of-process outside a transfer is ignored
        mask_wr = 1'b1; mask_wdata = 4'b0000;
        dreq_raw = 4'b0101; hold_ack = 1'b0; eop_in = 1'b1;
        step();
        mask_wr = 1'b0;
        chk("R3 hold state", 8'(hold_req), 8'd1);
        step();
        hold_ack = 1'b1; eop_in = 1'b0;
        step();
        chk("R10 S1 bus_own", 8'(bus_own), 8'd1);
        chk("R12 no step in S1", 8'(xfer_step), 8'd0);
        step(); step(); step();
        chk("R12 step in S4", 8'(xfer_step), 8'd1);
        step();
        chk("R8 ch0 continues", 8'(bus_own), 8'd1);
        chk("R11 hold kept", 8'(hold_req), 8'd1);
        chk("R12 step is one pulse", 8'(xfer_step), 8'd0);
        step(); step(); step();
        // R9: mask write of zeros in the same clock as a terminal count
        tc_hit = 4'b0001; mask_wr = 1'b1; mask_wdata = 4'b0000;
        step();
        chk("R7 idle after terminal count", 8'(hold_req), 8'd0);
        tc_hit = '0; mask_wr = 1'b0;
        step();
        chk("R9 termination beats mask write", 8'(hold_req), 8'd0);
        step();
        chk("R9 still masked", 8'(bus_own), 8'd0);

        // R9: reset sets every mask
        rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
        dreq_raw = 4'b1011;
        step();
        chk("R9 masked after reset", 8'(hold_req), 8'd0);
        step();
        chk("R9 still masked after reset", 8'(hold_req), 8'd0);
        chk("R2 dack at rest after reset", 8'(dack_raw), 8'h2);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule